// File: doc/BRIEF.md
# Multi-Mode Buzzer Tone Generator

This block turns a system clock into a square-wave buzzer drive. A three-bit code picks one of eight tone pitches between 625 Hz and 3 kHz. A two-bit code picks how the tone is gated in time:

- steady tone;
- one 100 ms burst;
- a 10 Hz on/off blink;
- 10 Hz blinking for the first half of every second, with silence for the second half.

All timing comes from one common tick at 60 kHz. The tick is derived from the system clock by an integer divide. Tone half-periods and the 50 ms pattern slots are both counted in that tick.

The controls are plain level inputs and are not a data stream, so there is no valid/ready handshake. While the block is enabled, software holds the enable, mode and pitch inputs steady. Changing the mode or the pitch, or enabling the block again, restarts the tone phase and the pattern from zero. In one-shot mode a busy flag covers the burst, and a one-clock done pulse marks its end. When the block is disabled, the output stays low.

Top module: `buzz_tone_gen`

## Requirements
- R1: While reset is asserted or `en_i` is low, `buzz_o`, `busy_o` and `done_o` are all 0.
- R2: Pitch code k = 0..7 selects 625, 1000, 1250, 1500, 1875, 2000, 2500 or 3000 Hz. The output half-period is 30000/f ticks (48, 30, 24, 20, 16, 15, 12 or 10). After a restart the tone starts in its low half.
- R3: Mode code 0 (steady) drives the tone without gating for as long as the block is enabled.
- R4: Mode code 1 (one-shot) drives the tone for the first two pattern slots (100 ms) after a restart. After that the output stays low until the next restart.
- R5: In mode code 1, `busy_o` is high from the restart until the burst ends. `done_o` is high for exactly one clock, in the cycle where `busy_o` first reads low.
- R6: Mode code 2 (blink) passes the tone during even-numbered 50 ms slots and silences it during odd-numbered slots, giving 10 Hz gating.
- R7: Mode code 3 (blink-per-second) uses slots numbered 0..19, wrapping every second. It passes the tone only in even slots below 10, so the first 500 ms blink and the rest is silent.
- R8: A change of mode or pitch while the block is enabled restarts the tone phase, the tick divider and the slot counters from zero.
- R9: One tick occurs every CLK_HZ/60000 clocks. Counting clock edges n from the restart edge, the number of ticks elapsed is floor(n/(CLK_HZ/60000)).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Block enable; low forces the output idle |
| mode_i | input | 2 | Gating pattern code (0 steady, 1 one-shot, 2 blink, 3 blink-per-second) |
| freq_i | input | 3 | Pitch code 0..7 |
| buzz_o | output | 1 | Square-wave buzzer drive |
| busy_o | output | 1 | One-shot burst in progress |
| done_o | output | 1 | One-clock pulse at the end of a one-shot burst |

## Verification
The bench builds the block with CLK_HZ = 180000, which gives three clocks per tick, and with SLOT_TICKS = 200 instead of 3000. With these values a whole one-second blink-per-second pattern fits in 12000 cycles. Every pitch code, every mode and every slot boundary can therefore be compared cycle by cycle against arithmetic on the edge count. The restarts caused by changes of pitch and mode, and the one-shot done edge at cycle 1200, all fall inside the run.

// File: rtl/buzz_pkg.sv
package buzz_pkg;

  // Common timing tick, in Hz
  localparam int unsigned TICK_HZ = 60000;
  localparam int unsigned HALF_W  = 6;

  typedef enum logic [1:0] {
    BZ_STEADY    = 2'd0,
    BZ_ONESHOT   = 2'd1,
    BZ_BLINK     = 2'd2,
    BZ_BLINK_SEC = 2'd3
  } bz_mode_e;

  // Half-period in ticks for each pitch code: TICK_HZ / (2 * f)
  function automatic logic [HALF_W-1:0] half_ticks(input logic [2:0] code);
    case (code)
      3'd0:    half_ticks = HALF_W'(48);  // 625 Hz
      3'd1:    half_ticks = HALF_W'(30);  // 1000 Hz
      3'd2:    half_ticks = HALF_W'(24);  // 1250 Hz
      3'd3:    half_ticks = HALF_W'(20);  // 1500 Hz
      3'd4:    half_ticks = HALF_W'(16);  // 1875 Hz
      3'd5:    half_ticks = HALF_W'(15);  // 2000 Hz
      3'd6:    half_ticks = HALF_W'(12);  // 2500 Hz
      default: half_ticks = HALF_W'(10);  // 3000 Hz
    endcase
  endfunction

endpackage

// File: rtl/buzz_prescale.sv
module buzz_prescale #(
  parameter int unsigned DIV = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV + 1) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  AST_PRESCALE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(DIV)); // R9

  AST_PRESCALE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0)); // R8

endmodule

// File: rtl/buzz_tone.sv
module buzz_tone
  import buzz_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       tick_i,
  input  logic [2:0] code_i,
  output logic       phase_o
);
  logic [HALF_W-1:0] cnt_q;
  logic [HALF_W-1:0] half;
  logic              wrap;

  assign half = half_ticks(code_i);
  assign wrap = tick_i && (cnt_q == half - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_o <= 1'b0;
    end else if (clr_i) begin
      cnt_q   <= '0;
      phase_o <= 1'b0;
    end else if (wrap) begin
      cnt_q   <= '0;
      phase_o <= ~phase_o;
    end else if (tick_i) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  AST_TONE_HALF_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |-> cnt_q < half); // R2

  AST_TONE_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !phase_o); // R2

endmodule

// File: rtl/buzz_pattern.sv
module buzz_pattern
  import buzz_pkg::*;
#(
  parameter int unsigned SLOT_TICKS = 3000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       tick_i,
  input  logic [1:0] mode_i,
  output logic       gate_o,
  output logic       fin_o,
  output logic       done_o
);
  localparam int unsigned SW        = $clog2(SLOT_TICKS + 1);
  localparam int unsigned SLOTS_SEC = 20;
  localparam int unsigned BURST     = 2;   // one-shot length in slots
  localparam int unsigned BLINK_END = 10;  // slots of blinking per second

  logic [SW-1:0] slot_cnt_q;
  logic [4:0]    slot_idx_q;
  logic          slot_end;

  assign slot_end = tick_i && (slot_cnt_q == SW'(SLOT_TICKS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_cnt_q <= '0;
      slot_idx_q <= '0;
      fin_o      <= 1'b0;
      done_o     <= 1'b0;
    end else if (clr_i) begin
      slot_cnt_q <= '0;
      slot_idx_q <= '0;
      fin_o      <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick_i && !fin_o) begin
        if (slot_end) begin
          slot_cnt_q <= '0;
          if (mode_i == BZ_ONESHOT && slot_idx_q == 5'(BURST - 1)) begin
            fin_o      <= 1'b1;
            done_o     <= 1'b1;
            slot_idx_q <= 5'(BURST);
          end else if (slot_idx_q == 5'(SLOTS_SEC - 1)) begin
            slot_idx_q <= '0;
          end else begin
            slot_idx_q <= slot_idx_q + 1'b1;
          end
        end else begin
          slot_cnt_q <= slot_cnt_q + 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (mode_i)
      BZ_STEADY:  gate_o = 1'b1;
      BZ_ONESHOT: gate_o = !fin_o;
      BZ_BLINK:   gate_o = !slot_idx_q[0];
      default:    gate_o = !slot_idx_q[0] && (slot_idx_q < 5'(BLINK_END));
    endcase
  end

  AST_SLOT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_idx_q < 5'(SLOTS_SEC)); // R7

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R5

  AST_FIN_HOLDS_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin_o && !clr_i) |=> $stable(slot_idx_q)); // R4

  AST_RESTART_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (slot_idx_q == '0 && !fin_o)); // R8

endmodule

// File: rtl/buzz_tone_gen.sv
module buzz_tone_gen
  import buzz_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 12000000,
  parameter int unsigned SLOT_TICKS = TICK_HZ / 20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] mode_i,
  input  logic [2:0] freq_i,
  output logic       buzz_o,
  output logic       busy_o,
  output logic       done_o
);
  localparam int unsigned TICK_DIV = (CLK_HZ / TICK_HZ > 0) ? CLK_HZ / TICK_HZ : 1;

  logic       en_q;
  logic [1:0] mode_q;
  logic [2:0] freq_q;
  logic       restart;
  logic       tick;
  logic       phase;
  logic       gate;
  logic       fin;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      mode_q <= '0;
      freq_q <= '0;
    end else begin
      en_q   <= en_i;
      mode_q <= mode_i;
      freq_q <= freq_i;
    end
  end

  assign restart = !en_i || !en_q || (mode_i != mode_q) || (freq_i != freq_q);

  buzz_prescale #(.DIV(TICK_DIV)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (restart),
    .tick_o(tick)
  );

  buzz_tone u_tone (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (restart),
    .tick_i (tick),
    .code_i (freq_i),
    .phase_o(phase)
  );

  buzz_pattern #(.SLOT_TICKS(SLOT_TICKS)) u_pat (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (restart),
    .tick_i(tick),
    .mode_i(mode_i),
    .gate_o(gate),
    .fin_o (fin),
    .done_o(done_o)
  );

  assign buzz_o = en_i && !restart && phase && gate;
  assign busy_o = en_i && (mode_i == BZ_ONESHOT) && !fin;

  AST_NO_DONE_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!en_i) |-> !done_o); // R1

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_o)); // R5

endmodule

// File: tb/sim_buzz_tone_gen.sv
module sim_buzz_tone_gen;
  localparam int unsigned CLK_HZ = 180000;  // three clocks per tick
  localparam int unsigned SLOT   = 200;
  localparam int unsigned DIV    = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [2:0] freq = 3'd0;
  logic       buzz, busy, done;

  int checks = 0;
  int errors = 0;
  int hz_tab [8] = '{625, 1000, 1250, 1500, 1875, 2000, 2500, 3000};

  always #2 clk = ~clk;  // 250 MHz

  buzz_tone_gen #(.CLK_HZ(CLK_HZ), .SLOT_TICKS(SLOT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .mode_i(mode), .freq_i(freq),
    .buzz_o(buzz), .busy_o(busy), .done_o(done)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic quiet(int cycles, string tag);
    @(negedge clk);
    en = 1'b0;
    for (int n = 0; n < cycles; n++) begin
      @(posedge clk); #1;
      chk(tag, "buzz idle", int'(buzz), 0);
      chk(tag, "busy idle", int'(busy), 0);
      chk(tag, "done idle", int'(done), 0);
    end
  endtask

  // Drive settings, then compare every cycle counted from the restart edge
  task automatic run_seq(int m, int f, int cycles, string tag);
    @(negedge clk);
    en   = 1'b1;
    mode = 2'(m);
    freq = 3'(f);
    for (int n = 0; n < cycles; n++) begin
      int t, h, s;
      bit ph, g, fin, eb, ed;
      @(posedge clk); #1;
      t   = n / DIV;
      h   = 30000 / hz_tab[f];
      ph  = ((t / h) % 2) == 1;
      s   = (t / SLOT) % 20;
      fin = (t >= 2 * SLOT);
      case (m)
        0:       g = 1'b1;
        1:       g = !fin;
        2:       g = (s % 2) == 0;
        default: g = ((s % 2) == 0) && (s < 10);
      endcase
      eb = (m == 1) && !fin;
      ed = (m == 1) && (n == DIV * 2 * SLOT);
      chk(tag, "buzz", int'(buzz), int'(ph && g));
      chk(tag, "busy", int'(busy), int'(eb));
      chk(tag, "done", int'(done), int'(ed));
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: outputs low during reset
    repeat (5) @(posedge clk);
    #1;
    chk("R1", "buzz in reset", int'(buzz), 0);
    chk("R1", "busy in reset", int'(busy), 0);
    chk("R1", "done in reset", int'(done), 0);
    @(negedge clk);
    rst_n = 1'b1;
    quiet(20, "R1");

    // R2 / R3 / R9: steady tone, every pitch code; pitch changes restart (R8)
    run_seq(0, 0, 700, "R3");
    for (int f = 1; f < 8; f++) run_seq(0, f, 700, "R2");

    // R4 / R5: one-shot burst, then a pitch change restarts it (R8)
    run_seq(1, 3, 1500, "R4");
    run_seq(1, 5, 1300, "R5");

    // R6: 10 Hz blink
    run_seq(2, 7, 2600, "R6");

    // R7: blink-per-second over more than one full second
    run_seq(3, 0, 12600, "R7");

    // R8: mode change in the middle of a pattern restarts it
    run_seq(3, 4, 1000, "R8");
    run_seq(2, 4, 1300, "R8");

    // R1: disable forces idle
    quiet(50, "R1");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule